// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps one address reservation per hardware context for a set of contexts that share a single memory. It takes one memory request per cycle. A request carries the issuing context, an access kind, an uncacheable flag and a physical address. A locked load opens a reservation. A conditional store asks whether the reservation still holds. Any write that reaches memory cancels every reservation on the same 16-byte granule.

For each conditional store the block returns a 2-bit result code with a one-cycle valid strobe. It also raises a write grant that tells the memory side whether the store may proceed. Each context has a counter of consecutive conditional-store failures. When that count reaches a multiple of a configurable period, the block emits a one-cycle warning pulse that names the context. All outputs are registered and appear in the cycle after the request. A request's effects, including its invalidation broadcast, are complete before the next request is seen.

Top module: `resv_monitor`

## Requirements
- R1: A locked load (kind 1) stores the full address as the issuing context's reservation and sets that context's reservation flag.
- R2: Reservation and store addresses are compared with the low 4 address bits ignored. A conditional store anywhere inside the reserved 16-byte granule matches.
- R3: A conditional store (kind 3) produces `res_valid` for exactly one cycle, one cycle after the request. No other kind produces it. A cacheable conditional store returns code 1 when the context's flag, taken before this request's update, is set and the granule matches. Otherwise it returns code 0. Code 3 never appears.
- R4: A failing cacheable conditional store clears its own context's flag and leaves `wr_grant` low. It also clears no other context's reservation.
- R5: An uncacheable conditional store skips the reservation check, returns code 2, asserts `wr_grant` and resets its context's failure counter.
- R6: `wr_grant` is asserted one cycle after a plain store (kind 2) and after any conditional store that passes or is uncacheable. Loads (kind 0) and locked loads never assert it.
- R7: Every granted write clears the reservation flag of each context whose reservation granule equals the written granule, the issuer included. Reservations on other granules survive.
- R8: Plain loads neither set nor clear any reservation.
- R9: Each failing cacheable conditional store increments its context's failure counter. A passing one resets the counter. `warn` pulses, with `warn_ctx` naming the context, whenever a failure brings the count to a multiple of `WARN_PERIOD`.
- R10: Synchronous active-high `rst` clears all reservation flags, addresses, failure counters and outputs.
- R11: Requests are accepted one per cycle. A request in the cycle directly after another sees all of the earlier request's updates, including broadcast clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTXW | Issuing context |
| req_kind | input | 2 | 0 load, 1 locked load, 2 store, 3 conditional store |
| req_uncached | input | 1 | Request targets uncacheable space |
| req_addr | input | AW | Physical address |
| res_valid | output | 1 | Conditional-store result strobe |
| res_code | output | 2 | 0 fail, 1 pass, 2 uncacheable |
| wr_grant | output | 1 | Memory write may proceed |
| warn | output | 1 | Failure count reached a multiple of the period |
| warn_ctx | output | CTXW | Context that raised `warn` |

## Verification
The bench checks the granule boundaries. An address inside the reserved granule must match and the neighbouring granule must not. A design that compared full addresses would fail the in-granule store. One that masked too many bits would pass the neighbour.

It checks that a failing conditional store leaves another context's reservation on the same granule alive. A design that broadcast on failure would make that later store fail. It also checks that the passing store's own flag is cleared, so a design that spared the issuer would pass the retry.

Counter behaviour is probed with a small period. The bench checks the success reset, the uncacheable reset and the reset pulse. A missing counter clear shows up as an early or missing warning.

// File: rtl/resv_monitor.sv
`timescale 1ns/1ps
module resv_monitor #(
  parameter int NCTX        = 4,
  parameter int AW          = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTXW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int CW   = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [CTXW-1:0] req_ctx,
  input  logic [1:0]      req_kind,
  input  logic            req_uncached,
  input  logic [AW-1:0]   req_addr,
  output logic            res_valid,
  output logic [1:0]      res_code,
  output logic            wr_grant,
  output logic            warn,
  output logic [CTXW-1:0] warn_ctx
);
  localparam logic [1:0] K_LD = 2'd0, K_LL = 2'd1, K_ST = 2'd2, K_SC = 2'd3;

  logic [AW-1:0]   rsv_addr [NCTX];
  logic [NCTX-1:0] rsv_flag;
  logic [CW-1:0]   fail_cnt [NCTX];

  logic [NCTX-1:0] gran_hit;
  for (genvar g = 0; g < NCTX; g++) begin : g_cmp
    assign gran_hit[g] = rsv_addr[g][AW-1:GRAN_BITS] == req_addr[AW-1:GRAN_BITS];
  end

  wire is_sc    = req_valid && req_kind == K_SC;
  wire own_ok   = rsv_flag[req_ctx] && gran_hit[req_ctx];
  wire sc_pass  = is_sc && !req_uncached && own_ok;
  wire sc_fail  = is_sc && !req_uncached && !own_ok;
  wire sc_unc   = is_sc && req_uncached;
  wire do_write = (req_valid && req_kind == K_ST) || sc_pass || sc_unc;
  wire cnt_wrap = fail_cnt[req_ctx] == CW'(WARN_PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_flag  <= '0;
      res_valid <= 1'b0;
      res_code  <= 2'd0;
      wr_grant  <= 1'b0;
      warn      <= 1'b0;
      warn_ctx  <= '0;
      for (int i = 0; i < NCTX; i++) begin
        rsv_addr[i] <= '0;
        fail_cnt[i] <= '0;
      end
    end else begin
      res_valid <= is_sc;
      res_code  <= sc_unc ? 2'd2 : (sc_pass ? 2'd1 : 2'd0);
      wr_grant  <= do_write;
      warn      <= sc_fail && cnt_wrap;
      warn_ctx  <= req_ctx;
      if (do_write)
        for (int i = 0; i < NCTX; i++)
          if (gran_hit[i]) rsv_flag[i] <= 1'b0;
      if (req_valid && req_kind == K_LL) begin
        rsv_addr[req_ctx] <= req_addr;
        rsv_flag[req_ctx] <= 1'b1;
      end
      if (sc_fail) begin
        rsv_flag[req_ctx] <= 1'b0;
        fail_cnt[req_ctx] <= cnt_wrap ? '0 : fail_cnt[req_ctx] + 1'b1;
      end
      if (sc_pass || sc_unc) fail_cnt[req_ctx] <= '0;
    end
  end

  logic armed, seen;
  always_ff @(posedge clk) begin
    seen  <= 1'b1;
    armed <= !rst;
  end

  p_ll_sets_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(req_valid && req_kind == K_LL) |-> rsv_flag[$past(req_ctx)]);
  p_code_legal_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    res_valid |-> res_code != 2'd3);
  p_res_from_sc_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    res_valid |-> $past(req_valid && req_kind == K_SC));
  p_fail_no_write_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (res_valid && res_code == 2'd0) |-> !wr_grant);
  p_unc_writes_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (res_valid && res_code == 2'd2) |-> wr_grant);
  p_grant_src_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    wr_grant |-> $past(req_valid && req_kind[1]));
  p_load_inert_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(req_valid && req_kind == K_LD) |-> rsv_flag == $past(rsv_flag));
  p_warn_on_fail_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    warn |-> (res_valid && res_code == 2'd0));
  p_reset_clears_r10: assert property (@(posedge clk) disable iff (!seen)
    $past(rst) |-> (rsv_flag == '0 && !res_valid && !wr_grant && !warn));
endmodule

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;
  localparam int NCTX = 4, AW = 32, PER = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_uncached = 1'b0;
  logic [1:0] req_ctx = '0, req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic res_valid, wr_grant, warn;
  logic [1:0] res_code, warn_ctx;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  resv_monitor #(.NCTX(NCTX), .AW(AW), .GRAN_BITS(4), .WARN_PERIOD(PER)) i_resv_monitor (
    .clk, .rst, .req_valid, .req_ctx, .req_kind, .req_uncached, .req_addr,
    .res_valid, .res_code, .wr_grant, .warn, .warn_ctx);

  // {ctx, kind, unc, addr[15:0], exp_valid, exp_code, exp_grant, exp_warn}
  localparam int NV = 27;
  localparam logic [25:0] TBL [NV] = '{
    {2'd0,2'd1,1'b0,16'h0100,1'b0,2'd0,1'b0,1'b0}, // R1 reserve
    {2'd0,2'd3,1'b0,16'h010C,1'b1,2'd1,1'b1,1'b0}, // R2 R3 in-granule pass
    {2'd0,2'd3,1'b0,16'h0100,1'b1,2'd0,1'b0,1'b0}, // R7 issuer cleared
    {2'd1,2'd1,1'b0,16'h0200,1'b0,2'd0,1'b0,1'b0},
    {2'd1,2'd3,1'b0,16'h0210,1'b1,2'd0,1'b0,1'b0}, // R2 neighbour granule fails
    {2'd1,2'd3,1'b0,16'h0200,1'b1,2'd0,1'b0,1'b0}, // R4 own flag cleared
    {2'd2,2'd1,1'b0,16'h0300,1'b0,2'd0,1'b0,1'b0},
    {2'd3,2'd1,1'b0,16'h0308,1'b0,2'd0,1'b0,1'b0},
    {2'd2,2'd3,1'b0,16'h0300,1'b1,2'd1,1'b1,1'b0},
    {2'd3,2'd3,1'b0,16'h0308,1'b1,2'd0,1'b0,1'b0}, // R7 broadcast clear
    {2'd0,2'd1,1'b0,16'h0400,1'b0,2'd0,1'b0,1'b0},
    {2'd1,2'd1,1'b0,16'h0400,1'b0,2'd0,1'b0,1'b0},
    {2'd1,2'd3,1'b0,16'h0500,1'b1,2'd0,1'b0,1'b0}, // R4 no grant
    {2'd0,2'd3,1'b0,16'h0400,1'b1,2'd1,1'b1,1'b0}, // R4 no broadcast on fail
    {2'd2,2'd1,1'b0,16'h0600,1'b0,2'd0,1'b0,1'b0},
    {2'd3,2'd2,1'b0,16'h060F,1'b0,2'd0,1'b1,1'b0}, // R6 plain store grant
    {2'd2,2'd3,1'b0,16'h0600,1'b1,2'd0,1'b0,1'b0}, // R7 R11 next-cycle view
    {2'd2,2'd1,1'b0,16'h0700,1'b0,2'd0,1'b0,1'b0},
    {2'd3,2'd2,1'b0,16'h0710,1'b0,2'd0,1'b1,1'b0},
    {2'd2,2'd3,1'b0,16'h0700,1'b1,2'd1,1'b1,1'b0}, // R7 other granule survives
    {2'd0,2'd1,1'b0,16'h0800,1'b0,2'd0,1'b0,1'b0},
    {2'd0,2'd0,1'b0,16'h0800,1'b0,2'd0,1'b0,1'b0}, // R8
    {2'd1,2'd0,1'b0,16'h0800,1'b0,2'd0,1'b0,1'b0}, // R8
    {2'd0,2'd3,1'b0,16'h0800,1'b1,2'd1,1'b1,1'b0}, // R8 reservation intact
    {2'd1,2'd1,1'b0,16'h0900,1'b0,2'd0,1'b0,1'b0},
    {2'd0,2'd3,1'b1,16'h0900,1'b1,2'd2,1'b1,1'b0}, // R5 uncacheable
    {2'd1,2'd3,1'b0,16'h0900,1'b1,2'd0,1'b0,1'b1}  // R7 R9 fourth failure on ctx1
  };

  task automatic issue(input int c, input int k, input bit u, input int a,
                       input bit ev, input int ec, input bit eg, input bit ew,
                       input int wc, input string tag);
    logic [4:0] got, exp;
    req_valid = 1'b1; req_ctx = 2'(c); req_kind = 2'(k);
    req_uncached = u; req_addr = AW'(a);
    @(posedge clk); #2;
    got = {res_valid, res_valid ? res_code : 2'd0, wr_grant, warn};
    exp = {ev, 2'(ec), eg, ew};
    tests++;
    if (got !== exp || (ew && warn_ctx !== 2'(wc))) begin
      fails++;
      $display("FAIL %s: {valid,code,grant,warn}=%b ctx=%0d expected %b ctx=%0d",
               tag, got, warn_ctx, exp, wc);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R10 outputs quiet in reset
    tests++;
    if ({res_valid, wr_grant, warn} !== 3'b000) begin
      fails++; $display("FAIL R10 reset outputs=%b expected 000", {res_valid, wr_grant, warn});
    end
    rst = 1'b0;
    // R1 R2 R3 R4 R6 R7 R8 R11 back-to-back table
    for (int i = 0; i < NV; i++)
      issue(TBL[i][25:24], TBL[i][23:22], TBL[i][21], TBL[i][20:5], TBL[i][4],
            TBL[i][3:2], TBL[i][1], TBL[i][0], 1, $sformatf("table step %0d", i));
    idle();

    // R10: reservation and counters cleared by reset
    issue(0, 1, 0, 'h0A00, 0, 0, 0, 0, 0, "R10 reserve before reset");
    issue(2, 3, 0, 'h0B00, 1, 0, 0, 0, 0, "R10 ctx2 fail 1");
    issue(2, 3, 0, 'h0B00, 1, 0, 0, 0, 0, "R10 ctx2 fail 2");
    rst = 1'b1;
    issue(0, 3, 0, 'h0A00, 0, 0, 0, 0, 0, "R10 request ignored in reset");
    rst = 1'b0;
    issue(0, 3, 0, 'h0A00, 1, 0, 0, 0, 0, "R10 reservation cleared");
    for (int n = 1; n <= 4; n++)
      issue(2, 3, 0, 'h0B00, 1, 0, 0, n == 4, 2, $sformatf("R10 counter cleared, fail %0d", n));

    // R9: success resets the counter
    issue(3, 3, 0, 'h0C00, 1, 0, 0, 0, 3, "R9 ctx3 fail 1");
    issue(3, 3, 0, 'h0C00, 1, 0, 0, 0, 3, "R9 ctx3 fail 2");
    issue(3, 1, 0, 'h0C00, 0, 0, 0, 0, 3, "R9 ctx3 reserve");
    issue(3, 3, 0, 'h0C04, 1, 1, 1, 0, 3, "R9 ctx3 pass");
    for (int n = 1; n <= 4; n++)
      issue(3, 3, 0, 'h0C00, 1, 0, 0, n == 4, 3, $sformatf("R9 after pass, fail %0d", n));

    // R5: uncacheable conditional store resets the counter
    issue(0, 3, 0, 'h0D00, 1, 0, 0, 0, 0, "R5 ctx0 fail 2");
    issue(0, 3, 0, 'h0D00, 1, 0, 0, 0, 0, "R5 ctx0 fail 3");
    issue(0, 3, 1, 'h0D00, 1, 2, 1, 0, 0, "R5 uncacheable code");
    for (int n = 1; n <= 4; n++)
      issue(0, 3, 0, 'h0D00, 1, 0, 0, n == 4, 0, $sformatf("R5 after uncacheable, fail %0d", n));

    // R3: a single result strobe
    idle();
    tests++;
    if (res_valid !== 1'b0) begin
      fails++; $display("FAIL R3 strobe held: res_valid=%b expected 0", res_valid);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule